// File: doc/BRIEF.md
# Microprogram Sequencer with Control Store

This block is a microcoded control engine. A 10-bit microprogram counter addresses a small control store that lives in the RTL as constant logic. Each stored word carries a group of control signals for the datapath, an end-of-instruction marker, a 2-bit next-address select, a 3-bit branch-test code and a 10-bit literal branch address. Every clock the sequencer evaluates the word's branch test against two datapath flags and loads the counter from one of four sources: the incremented counter, a start address decoded from the 5-bit macro-opcode, an external vector, or the literal field.

A synchronous reset and a synchronous exception input both force the external path. A 2-to-1 selector supplies the external vector: 0 for reset and 400 for exception. Reset wins when both are high. The control signals and the end marker of the word at the current address drive the outputs combinationally. The current address is also brought out so that the surrounding control logic can observe it.

Top module: `useq_sequencer`

## Requirements
- R1: A clock edge with `rst_i` high sets `uaddr_o` to 0. At address 0, `ctrl_o` is all zeros and `last_o` is 0. Word 0 is a bare branch test that goes unconditionally to 100 on the next edge.
- R2: The fetch steps run 100, 101, 102, with `ctrl_o` equal to 12'h001, 12'h002 and 12'h004. Word 101 holds select 11 and branch address 200 but branch code 101 (never branch), so it still advances to 102.
- R3: Word 102 jumps unconditionally (code 000, select 01) to the opcode start address. The map is: opcode 1 to 200, 2 to 300, 3 to 320, 4 to 340, 5 to 360. Every other opcode goes to 100.
- R4: The add routine steps 200, 201, 202 with `ctrl_o` 12'h010, 12'h020 and 12'h040. Word 202 raises `last_o` and branches unconditionally to 100.
- R5: Flag tests work as follows. Code 010 (word 300, target 310) branches when `cond_i` is 1. Code 001 (word 340, target 350) branches when `cond_i` is 0. If the test fails, the next address is the current address plus one.
- R6: Counter tests work as follows. Code 100 (word 320, target 320) repeats while `czero_i` is 0 and falls through to 321 when it is 1. Code 011 (word 341, target 350) branches when `czero_i` is 1 and falls through to 342 otherwise.
- R7: Select 10 (word 360, code 000) loads the external vector. With no exception pending, that vector is 0.
- R8: With `rst_i` low, `exc_i` high at an edge loads 400, whatever the current word would have chosen. Word 400 drives `ctrl_o` 12'h800. Word 401 raises `last_o` and returns to 100.
- R9: When `rst_i` and `exc_i` are both high at an edge, the counter loads 0.
- R10: `last_o` is 1 only at the routine-final words 202, 301, 310, 321, 342, 350 and 401, and each of these returns to 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, forces the external vector 0 |
| exc_i | input | 1 | Synchronous exception, forces the external vector 400 |
| opcode_i | input | 5 | Macro-opcode used by the start-address map |
| cond_i | input | 1 | Datapath branch-condition flag |
| czero_i | input | 1 | Datapath counter-is-zero flag |
| ctrl_o | output | 12 | Control-signal field of the current word |
| last_o | output | 1 | End-of-macro-instruction marker of the current word |
| uaddr_o | output | 10 | Current microprogram counter |

## Verification
Two functions can fall in the same cycle. The first case is an exception edge on a word that would itself redirect the counter. The bench raises `exc_i` while the counter sits at 102 with a mapped opcode, and again inside the counter loop at 320 with the flag saying "repeat". In both cases the next address must be 400, not the start address and not the loop target. The second case has reset and exception high on the same edge; the counter must read 0, showing the fixed priority of the external selector.

// File: rtl/useq_pkg.sv
package useq_pkg;
   typedef enum logic [1:0] {
      SEL_INC   = 2'b00,
      SEL_START = 2'b01,
      SEL_EXT   = 2'b10,
      SEL_BADDR = 2'b11
   } nsel_e;

   typedef enum logic [2:0] {
      BC_ALWAYS = 3'b000,
      BC_FLAG0  = 3'b001,
      BC_FLAG1  = 3'b010,
      BC_CZERO  = 3'b011,
      BC_CNZ    = 3'b100,
      BC_NONE   = 3'b101
   } bcode_e;

   localparam int ADR_RESET = 0;
   localparam int ADR_FETCH = 100;
   localparam int ADR_EXC   = 400;
endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int UA_W   = 10,
   parameter int CTRL_W = 12
) (
   input  logic [UA_W-1:0]   upc_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              last_o,
   output nsel_e             sel_o,
   output bcode_e            bc_o,
   output logic [UA_W-1:0]   baddr_o
);
   localparam logic [UA_W-1:0] FETCH = UA_W'(ADR_FETCH);

   // default word: no signals, step to the next address
   always_comb begin
      ctrl_o  = '0;
      last_o  = 1'b0;
      sel_o   = SEL_INC;
      bc_o    = BC_NONE;
      baddr_o = '0;
      case (upc_i)
         UA_W'(0):   begin sel_o = SEL_BADDR; bc_o = BC_ALWAYS; baddr_o = FETCH; end
         UA_W'(100): ctrl_o = CTRL_W'(12'h001);
         UA_W'(101): begin ctrl_o = CTRL_W'(12'h002); sel_o = SEL_BADDR; baddr_o = UA_W'(200); end
         UA_W'(102): begin ctrl_o = CTRL_W'(12'h004); sel_o = SEL_START; bc_o = BC_ALWAYS; end
         UA_W'(200): ctrl_o = CTRL_W'(12'h010);
         UA_W'(201): ctrl_o = CTRL_W'(12'h020);
         UA_W'(202): begin ctrl_o = CTRL_W'(12'h040); last_o = 1'b1;
                           sel_o = SEL_BADDR; bc_o = BC_ALWAYS; baddr_o = FETCH; end
         UA_W'(300): begin ctrl_o = CTRL_W'(12'h100); sel_o = SEL_BADDR; bc_o = BC_FLAG1;
                           baddr_o = UA_W'(310); end
         UA_W'(301), UA_W'(321), UA_W'(342), UA_W'(350), UA_W'(401):
                     begin last_o = 1'b1; sel_o = SEL_BADDR; bc_o = BC_ALWAYS; baddr_o = FETCH; end
         UA_W'(310): begin ctrl_o = CTRL_W'(12'h200); last_o = 1'b1;
                           sel_o = SEL_BADDR; bc_o = BC_ALWAYS; baddr_o = FETCH; end
         UA_W'(320): begin ctrl_o = CTRL_W'(12'h400); sel_o = SEL_BADDR; bc_o = BC_CNZ;
                           baddr_o = UA_W'(320); end
         UA_W'(340): begin sel_o = SEL_BADDR; bc_o = BC_FLAG0; baddr_o = UA_W'(350); end
         UA_W'(341): begin sel_o = SEL_BADDR; bc_o = BC_CZERO; baddr_o = UA_W'(350); end
         UA_W'(360): begin sel_o = SEL_EXT; bc_o = BC_ALWAYS; end
         UA_W'(400): ctrl_o = CTRL_W'(12'h800);
         default: ;
      endcase
   end
endmodule

// File: rtl/useq_startmap.sv
module useq_startmap
   import useq_pkg::*;
#(
   parameter int OP_W = 5,
   parameter int UA_W = 10
) (
   input  logic [OP_W-1:0] opcode_i,
   output logic [UA_W-1:0] start_o
);
   always_comb begin
      case (opcode_i)
         OP_W'(1): start_o = UA_W'(200);
         OP_W'(2): start_o = UA_W'(300);
         OP_W'(3): start_o = UA_W'(320);
         OP_W'(4): start_o = UA_W'(340);
         OP_W'(5): start_o = UA_W'(360);
         default:  start_o = UA_W'(ADR_FETCH);
      endcase
   end
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int UA_W = 10
) (
   input  logic [UA_W-1:0] upc_i,
   input  logic            rst_i,
   input  logic            exc_i,
   input  logic            cond_i,
   input  logic            czero_i,
   input  nsel_e           sel_i,
   input  bcode_e          bc_i,
   input  logic [UA_W-1:0] baddr_i,
   input  logic [UA_W-1:0] start_i,
   output logic [UA_W-1:0] next_o
);
   logic [UA_W-1:0] inc, ext, mux;
   logic            take;

   assign inc = upc_i + UA_W'(1);
   // 2-to-1 external vector, reset side wins
   assign ext = rst_i ? UA_W'(ADR_RESET) : (exc_i ? UA_W'(ADR_EXC) : UA_W'(ADR_RESET));

   always_comb begin
      case (bc_i)
         BC_ALWAYS: take = 1'b1;
         BC_FLAG0:  take = ~cond_i;
         BC_FLAG1:  take = cond_i;
         BC_CZERO:  take = czero_i;
         BC_CNZ:    take = ~czero_i;
         default:   take = 1'b0;
      endcase
      case (sel_i)
         SEL_INC:   mux = inc;
         SEL_START: mux = start_i;
         SEL_EXT:   mux = ext;
         default:   mux = baddr_i;
      endcase
      if (rst_i || exc_i) next_o = ext;
      else if (take)      next_o = mux;
      else                next_o = inc;
   end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
   import useq_pkg::*;
#(
   parameter int UA_W   = 10,
   parameter int OP_W   = 5,
   parameter int CTRL_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              exc_i,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic              cond_i,
   input  logic              czero_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              last_o,
   output logic [UA_W-1:0]   uaddr_o
);
   localparam int MAX_ADR = (1 << UA_W) - 1;

   generate
      if (MAX_ADR < ADR_EXC + 1) begin : g_bad_ua
         $error("useq_sequencer: UA_W too small for the vector map");
      end
      if (CTRL_W < 12) begin : g_bad_ctrl
         $error("useq_sequencer: CTRL_W must be at least 12");
      end
      if (OP_W < 3) begin : g_bad_op
         $error("useq_sequencer: OP_W must be at least 3");
      end
   endgenerate

   logic [UA_W-1:0] upc_q, upc_d, start, baddr;
   nsel_e           sel;
   bcode_e          bc;

   useq_store #(.UA_W(UA_W), .CTRL_W(CTRL_W)) u_store (
      .upc_i(upc_q), .ctrl_o(ctrl_o), .last_o(last_o),
      .sel_o(sel), .bc_o(bc), .baddr_o(baddr)
   );

   useq_startmap #(.OP_W(OP_W), .UA_W(UA_W)) u_map (
      .opcode_i(opcode_i), .start_o(start)
   );

   useq_next #(.UA_W(UA_W)) u_next (
      .upc_i(upc_q), .rst_i(rst_i), .exc_i(exc_i), .cond_i(cond_i),
      .czero_i(czero_i), .sel_i(sel), .bc_i(bc), .baddr_i(baddr),
      .start_i(start), .next_o(upc_d)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) upc_q <= UA_W'(ADR_RESET);
      else       upc_q <= upc_d;
   end

   assign uaddr_o = upc_q;

   // R1 / R9: reset edge always lands on address 0
   p_reset_vec_r1: assert property (@(posedge clk_i)
      rst_i |=> (upc_q == UA_W'(ADR_RESET)));

   // R8: exception forces the 400 vector
   p_exc_vec_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      exc_i |=> (upc_q == UA_W'(ADR_EXC)));

   // R2: a never-branch word advances by one
   p_nobranch_inc_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!exc_i && bc == BC_NONE) |=> (upc_q == $past(upc_q) + UA_W'(1)));

   // R3: last fetch step lands on the mapped start address
   p_start_jump_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!exc_i && upc_q == UA_W'(102)) |=> (upc_q == $past(start)));

   // R10: an end-marked word returns to fetch
   p_last_return_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (!exc_i && last_o) |=> (upc_q == UA_W'(ADR_FETCH)));
endmodule

// File: tb/sim_useq_sequencer.sv
`timescale 1ns/1ps
module sim_useq_sequencer;
   logic        clk = 1'b0;
   logic        rst, exc, cond, cz;
   logic [4:0]  op;
   logic [11:0] ctrl;
   logic        last;
   logic [9:0]  uaddr;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   useq_sequencer u0 (
      .clk_i(clk), .rst_i(rst), .exc_i(exc), .opcode_i(op),
      .cond_i(cond), .czero_i(cz), .ctrl_o(ctrl), .last_o(last), .uaddr_o(uaddr)
   );

   // {tag[21:18], op[17:13], cond[12], czero[11], exc[10], expected address[9:0]}
   localparam int NV = 52;
   localparam logic [21:0] VEC [NV] = '{
      {4'd1,5'd0,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd102},
      {4'd3,5'd1,1'b0,1'b0,1'b0,10'd200},
      {4'd4,5'd0,1'b0,1'b0,1'b0,10'd201},
      {4'd4,5'd0,1'b0,1'b0,1'b0,10'd202},
      {4'd4,5'd0,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd102},
      {4'd3,5'd2,1'b0,1'b0,1'b0,10'd300},
      {4'd5,5'd0,1'b1,1'b0,1'b0,10'd310},
      {4'd10,5'd0,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd102},
      {4'd3,5'd2,1'b0,1'b0,1'b0,10'd300},
      {4'd5,5'd0,1'b0,1'b0,1'b0,10'd301},
      {4'd10,5'd0,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd102},
      {4'd3,5'd3,1'b0,1'b0,1'b0,10'd320},
      {4'd6,5'd0,1'b0,1'b0,1'b0,10'd320},
      {4'd6,5'd0,1'b0,1'b0,1'b0,10'd320},
      {4'd6,5'd0,1'b0,1'b1,1'b0,10'd321},
      {4'd10,5'd0,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd102},
      {4'd3,5'd4,1'b0,1'b0,1'b0,10'd340},
      {4'd5,5'd0,1'b1,1'b0,1'b0,10'd341},
      {4'd6,5'd0,1'b0,1'b1,1'b0,10'd350},
      {4'd10,5'd0,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd102},
      {4'd3,5'd4,1'b0,1'b0,1'b0,10'd340},
      {4'd5,5'd0,1'b0,1'b0,1'b0,10'd350},
      {4'd10,5'd0,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd102},
      {4'd3,5'd5,1'b0,1'b0,1'b0,10'd360},
      {4'd7,5'd0,1'b0,1'b0,1'b0,10'd0},
      {4'd1,5'd0,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd8,5'd0,1'b0,1'b0,1'b1,10'd400},
      {4'd8,5'd0,1'b0,1'b0,1'b0,10'd401},
      {4'd8,5'd0,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd102},
      {4'd3,5'd9,1'b0,1'b0,1'b0,10'd100},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd101},
      {4'd2,5'd0,1'b0,1'b0,1'b0,10'd102},
      {4'd8,5'd1,1'b0,1'b0,1'b1,10'd400},
      {4'd8,5'd0,1'b0,1'b0,1'b0,10'd401},
      {4'd8,5'd0,1'b0,1'b0,1'b0,10'd100}
   };

   task automatic chk(input int tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL R%0d %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic x, input logic [4:0] o,
                       input logic c, input logic z);
      @(negedge clk);
      rst = r; exc = x; op = o; cond = c; cz = z;
      @(posedge clk);
      #1;
   endtask

   initial begin
      rst = 1'b1; exc = 1'b0; op = '0; cond = 1'b0; cz = 1'b0;
      step(1'b1, 1'b0, 5'd0, 1'b0, 1'b0);
      // R1: reset state
      chk(1, "reset address", int'(uaddr), 0);
      chk(1, "reset ctrl zero", int'(ctrl), 0);
      chk(1, "reset last low", int'(last), 0);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R10
      for (int i = 0; i < NV; i++) begin
         step(1'b0, VEC[i][10], VEC[i][17:13], VEC[i][12], VEC[i][11]);
         chk(int'(VEC[i][21:18]), $sformatf("table step %0d address", i),
             int'(uaddr), int'(VEC[i][9:0]));
      end

      // directed corner cases
      step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0);                // 101
      step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0);                // 102
      chk(2, "fetch word 102 ctrl", int'(ctrl), 12'h004);
      step(1'b0, 1'b0, 5'd1, 1'b0, 1'b0);                // 200
      chk(4, "add word 200 ctrl", int'(ctrl), 12'h010);
      step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0);                // 202
      chk(4, "add word 202 last", int'(last), 1);
      chk(10, "add word 202 ctrl", int'(ctrl), 12'h040);
      step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0);                // 100
      chk(2, "fetch word 100 ctrl", int'(ctrl), 12'h001);
      chk(10, "fetch word 100 last low", int'(last), 0);
      step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 5'd3, 1'b0, 1'b0);                // 320
      step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0);                // loop 320
      chk(6, "loop holds on nonzero", int'(uaddr), 320);
      // R8: exception beats the taken loop branch
      step(1'b0, 1'b1, 5'd0, 1'b0, 1'b0);
      chk(8, "exception over loop", int'(uaddr), 400);
      chk(8, "exception word ctrl", int'(ctrl), 12'h800);
      // R9: reset and exception together
      step(1'b1, 1'b1, 5'd0, 1'b0, 1'b0);
      chk(9, "reset beats exception", int'(uaddr), 0);
      step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
      chk(1, "word 0 goes to fetch", int'(uaddr), 100);

      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(20000 * 5);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule